// File: doc/BRIEF.md
# Audio Transmit FIFO Register and Interrupt Block

This block sits between a processor bus and the serializer of an audio transmit path. Software writes sample words into a transmit FIFO through a group of data addresses. It programs a configuration word and an interrupt mask, and reads a status word that shows the live condition of the FIFO. The serializer drains the FIFO through a pop handshake. It also reads the configuration word from a dedicated output.

One interrupt line is raised from two conditions, both selected by the mask and gated by an enable bit in the configuration:

- The FIFO is empty.
- The FIFO fill has dropped below a threshold.

The threshold is a power-of-two fraction of the FIFO depth, chosen by a four-bit code in the configuration. The two condition bits track the FIFO as it is and are never latched. Writes that arrive while the FIFO is full are discarded, and they set a sticky flag that software clears.

The bus is a single valid strobe with a write flag, a byte address, write data and registered read data.

Top module: `aud_fifo_irq_regs`

## Requirements
- R1: After reset the following hold: the configuration reads 0, the mask reads 0, the FIFO is empty, the status reads 0x3, `irq` is 0 and `pop_avail` is 0.
- R2: A read whose strobe is seen on a clock edge presents its data on `bus_rdata` from that edge until the next read. Address 0x00 returns the `VERSION` parameter, and writes to 0x00 change nothing.
- R3: Address 0x04 holds the configuration. Only the bits in 0xFF3F_FF07 are stored, and the other bits read as 0. The stored word drives `cfg_word`. The threshold code sits in bits 27:24 and the interrupt enable in bit 1.
- R4: Address 0x08 holds the interrupt mask in bits 1:0, and its other bits read as 0. Mask bit 0 selects the empty condition and mask bit 1 selects the below-threshold condition.
- R5: A write to any of 0x10, 0x14, 0x18 or 0x1C pushes the 32-bit write data into the FIFO. The serializer receives the words in write order on `pop_data`, and each `pop_req` while `pop_avail` is 1 removes one word. Reads of 0x10 through 0x1C return 0.
- R6: Status bit 0 at address 0x0C is 1 exactly when the FIFO is empty, and `pop_avail` is its inverse.
- R7: Status bit 1 is 1 exactly when the fill count is below T. T is (DEPTH/2) >> (L-1) for a code L of 1 to 15, and T is DEPTH/2 for L = 0. A shift result of 0 means the bit never sets.
- R8: `irq` equals the interrupt enable (bit 1 of the configuration) ANDed with the OR of (status bits 1:0 AND mask bits 1:0).
- R9: A data write while the FIFO is full is dropped and sets the sticky status bit 2. Writing 1 to status bit 2 clears it. Bit 2 never drives `irq`.
- R10: Writing ones to status bits 1:0 does not clear them while their conditions still hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pop_req | input | 1 | Serializer takes the head word |
| pop_data | output | 32 | Head word of the FIFO |
| pop_avail | output | 1 | FIFO holds at least one word |
| cfg_word | output | 32 | Stored configuration for the serializer |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check these properties on every cycle:

- A status read reports the empty condition that held when the read was taken.
- Data and version reads return 0 and the version constant.
- The interrupt stays low while its enable is clear.
- The fill count never exceeds the depth, and it does not rise while the FIFO is full.

Other behaviours are visible only through the bench scenarios. These are the threshold for each of the sixteen level codes across every fill count, the interplay of mask and enable with the status bits, FIFO ordering across a dropped write, the clearing of the sticky overflow flag, and the reset values.

// File: rtl/aud_fifo_irq_regs.sv
module aud_fifo_irq_regs #(
  parameter int          DEPTH   = 64,
  parameter logic [31:0] VERSION = 32'h0001_0002
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        pop_req,
  output logic [31:0] pop_data,
  output logic        pop_avail,
  output logic [31:0] cfg_word,
  output logic        irq
);
  localparam int          PW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int          CW       = PW + 1;
  localparam logic [CW-1:0] HALF   = CW'(DEPTH / 2);
  localparam logic [CW-1:0] FULL   = CW'(DEPTH);
  localparam logic [31:0] CFG_MASK = 32'hFF3F_FF07;

  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [31:0]   cfg;
  logic [1:0]    msk;
  logic          ovf;

  wire [2:0] sel      = bus_addr[4:2];
  wire       wr       = bus_valid & bus_write;
  wire       rd       = bus_valid & ~bus_write;
  wire       push_req = wr & sel[2];
  wire       full     = (cnt == FULL);
  wire       push     = push_req & ~full;
  wire       drop     = push_req & full;
  wire       pop      = pop_req & (cnt != '0);

  wire [3:0]    lvl   = cfg[27:24];
  wire [3:0]    shamt = (lvl == 4'd0) ? 4'd0 : lvl - 4'd1;
  wire [CW-1:0] thr   = HALF >> shamt;
  wire [31:0]   stat  = {29'b0, ovf, (cnt < thr), (cnt == '0)};

  always_ff @(posedge clk)
    if (push) mem[wp] <= bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
      msk <= '0;
      ovf <= 1'b0;
    end else begin
      if (wr && sel == 3'd1) cfg <= bus_wdata & CFG_MASK;
      if (wr && sel == 3'd2) msk <= bus_wdata[1:0];
      if (drop) ovf <= 1'b1;
      else if (wr && sel == 3'd3 && bus_wdata[2]) ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd) begin
      case (sel)
        3'd0:    bus_rdata <= VERSION;
        3'd1:    bus_rdata <= cfg;
        3'd2:    bus_rdata <= {30'b0, msk};
        3'd3:    bus_rdata <= stat;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign pop_data  = mem[rp];
  assign pop_avail = (cnt != '0);
  assign cfg_word  = cfg;
  assign irq       = cfg[1] & |(stat[1:0] & msk);
endmodule

// File: rtl/aud_fifo_irq_regs_chk.sv
module aud_fifo_irq_regs_chk #(
  parameter int          DEPTH   = 64,
  parameter logic [31:0] VERSION = 32'h0,
  parameter int          CW      = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [4:0]    bus_addr,
  input logic [31:0]   bus_rdata,
  input logic          pop_req,
  input logic          pop_avail,
  input logic [31:0]   cfg_word,
  input logic          irq,
  input logic [CW-1:0] cnt
);
  wire rd = bus_valid && !bus_write;

  assert_underrun_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr[4:2] == 3'd3) |=> (bus_rdata[0] == !$past(pop_avail)));

  assert_data_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr[4]) |=> (bus_rdata == 32'h0));

  assert_version_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr[4:2] == 3'd0) |=> (bus_rdata == VERSION));

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_word[1] |-> !irq);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && !pop_req) |=> (cnt == CW'(DEPTH)));
endmodule

bind aud_fifo_irq_regs aud_fifo_irq_regs_chk #(
  .DEPTH(DEPTH), .VERSION(VERSION), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pop_req(pop_req),
  .pop_avail(pop_avail), .cfg_word(cfg_word), .irq(irq), .cnt(cnt)
);

// File: tb/aud_fifo_irq_regs_bench.sv
module aud_fifo_irq_regs_bench;
  localparam int          D   = 16;
  localparam logic [31:0] VER = 32'hA5C3_0101;

  logic        clk = 0, rst_n = 0;
  logic        bus_valid = 0, bus_write = 0, pop_req = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, pop_data, cfg_word;
  logic        pop_avail, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  aud_fifo_irq_regs #(.DEPTH(D), .VERSION(VER)) u_aud_fifo_irq_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pop_req(pop_req), .pop_data(pop_data), .pop_avail(pop_avail),
    .cfg_word(cfg_word), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
  endtask

  task automatic pop(output logic [31:0] d);
    @(negedge clk);
    d = pop_data;
    pop_req = 1;
    @(negedge clk);
    pop_req = 0;
  endtask

  function automatic int thr_of(input int l);
    int s;
    s = (l == 0) ? 0 : l - 1;
    return (D / 2) >> s;
  endfunction

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 pop_avail", {31'b0, pop_avail}, 0);
    rd(5'h04, v); chk("R1 cfg", v, 0);
    rd(5'h08, v); chk("R1 mask", v, 0);
    rd(5'h0C, v); chk("R1 status", v, 32'h3);

    rd(5'h00, v); chk("R2 version", v, VER);
    wr(5'h00, 32'h1234_5678);
    rd(5'h00, v); chk("R2 version write ignored", v, VER);
    rd(5'h04, v); chk("R2 version write leaves cfg", v, 0);

    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, v); chk("R3 cfg mask", v, 32'hFF3F_FF07);
    chk("R3 cfg_word", cfg_word, 32'hFF3F_FF07);
    wr(5'h04, 32'h0000_0000);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, v); chk("R4 mask bits", v, 32'h3);
    chk("R8 irq off without enable", {31'b0, irq}, 0);

    wr(5'h0C, 32'h3);
    rd(5'h0C, v); chk("R10 ack while empty", v, 32'h3);

    for (int a = 0; a < 4; a++) begin
      rd(5'(5'h10 + 4 * a), v); chk("R5 data read zero", v, 0);
    end

    for (int l = 0; l < 16; l++) begin
      int t;
      logic [1:0] m;
      t = thr_of(l);
      m = 2'((l % 3) + 1);
      wr(5'h04, {4'h1, 4'(l), 22'h0, 2'b10});
      wr(5'h08, {30'b0, m});
      for (int n = 0; n <= D; n++) begin
        logic [1:0] st;
        st = {(n < t), (n == 0)};
        rd(5'h0C, v);
        chk($sformatf("R7 status L=%0d n=%0d", l, n), v, {30'b0, st});
        chk("R6 pop_avail", {31'b0, pop_avail}, {31'b0, n != 0});
        chk($sformatf("R8 irq L=%0d n=%0d", l, n), {31'b0, irq}, {31'b0, |(st & m)});
        if (n == 3 && st != 0) begin
          wr(5'h0C, 32'h3);
          rd(5'h0C, v); chk("R10 ack with condition held", v, {30'b0, st});
        end
        if (n < D) wr(5'(5'h10 + 4 * (n % 4)), 32'(l * 256 + n));
      end
      wr(5'h14, 32'hDEAD_BEEF);
      rd(5'h0C, v); chk("R9 overflow sticky", v, (t > D) ? 32'h6 : 32'h4);
      if (l == 15) begin
        wr(5'h08, 32'h3);
        chk("R9 overflow no irq", {31'b0, irq}, 0);
      end
      wr(5'h0C, 32'h4);
      rd(5'h0C, v); chk("R9 overflow cleared", v, 0);
      for (int n = 0; n < D; n++) begin
        pop(v);
        chk("R5 order", v, 32'(l * 256 + n));
      end
      chk("R6 empty after drain", {31'b0, pop_avail}, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule